// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a synchronous DRAM and turns what it samples at each rising clock edge into one command code. It also keeps an open or closed state for each bank and flags commands that the current bank state does not allow.

A memory controller's checker, or a model of the memory's front end, connects it next to the pins. The bank state is not an output. It shows only through the illegal-command flag on later commands. The bank state changes on activates, precharges and auto-precharges that finish.

The block also follows the clock-enable pin. It tells power-down apart from clock suspend by checking whether a burst is still running. While clock enable stays low, the burst count and the auto-precharge countdowns are frozen.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted, and after it, the outputs are NOP (code 0) with autoPre, allBanks and illegalCmd low, and every bank is closed. Reset also sets the remembered clock-enable level to high.
- R2: All inputs are sampled on the rising clock edge. The outputs present the result for that edge until the next edge. cmdBank always carries the bank bits sampled at that edge.
- R3: With clock enable high at this edge and the one before, and chip select low, the {row, column, write-enable} strobes decode as follows: 011 ACTIVATE (2), 101 READ (3), 100 WRITE (4), 010 PRECHARGE (5), 001 AUTO_REF (6), 000 MODE_SET (7), 110 BURST_STOP (8), 111 NOP (0).
- R4: Chip select high, with clock enable high in both cycles, gives DESELECT (1). An auto-precharge or a burst already in progress keeps running through it.
- R5: Address bit 10 sets autoPre on READ and WRITE, and sets allBanks on PRECHARGE. A PRECHARGE with allBanks closes every bank whatever the bank bits are. Otherwise the bank bits choose the bank.
- R6: Clock enable going low with chip select low and strobes 001 gives SELF_REF (9). While clock enable stays low, the code is CKE_HOLD (13) and the pins are ignored. The edge where clock enable returns high gives CKE_EXIT (12), so a refresh pattern there is not an AUTO_REF.
- R7: Clock enable going low with any other pattern gives SUSPEND (11) if a burst is running, and POWER_DOWN (10) if not. A legal READ or WRITE starts a burst of BURST_LEN counted edges. With no freeze, SUSPEND is decoded up to the BURST_LEN-th edge after it.
- R8: ACTIVATE needs its bank closed. READ and WRITE need their bank open. BURST_STOP needs at least one open bank. AUTO_REF, MODE_SET and SELF_REF need every bank closed.
- R9: A legal ACTIVATE opens its bank. A legal PRECHARGE closes its target bank or banks.
- R10: A legal READ or WRITE with autoPre closes its bank AP_DELAY edges later. An ACTIVATE to that bank is illegal at the AP_DELAY-th edge after the command and legal at the next edge.
- R11: A violation raises illegalCmd for exactly the cycle that reports that command. Bank state and burst state stay as they were.
- R12: A legal BURST_STOP ends the running burst, or a PRECHARGE does so when it covers the burst's bank. A clock-enable fall right after it decodes POWER_DOWN.
- R13: An edge that samples clock enable low does not advance the burst count or any auto-precharge countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable pin level |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr10 | input | 1 | Address bit 10 (auto-precharge / all-banks select) |
| bankSel | input | BANK_W | Bank-select bits |
| cmdCode | output | 4 | Decoded command code (see R3, R4, R6, R7) |
| cmdBank | output | BANK_W | Bank bits that go with cmdCode |
| autoPre | output | 1 | READ/WRITE carries auto-precharge |
| allBanks | output | 1 | PRECHARGE targets all banks |
| illegalCmd | output | 1 | Command violates the current bank state |

## Verification
The bench builds the block with four banks, BURST_LEN of 4 and AP_DELAY of 3. With these values the edges where suspend turns into power-down, and where an auto-precharged bank can be activated again, fall within a few cycles of the triggering command. Each boundary is driven on both sides. The frozen-count case is arranged so that a count that wrongly kept running would decode power-down where suspend is expected.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP        = 4'd0,
    CMD_DESELECT   = 4'd1,
    CMD_ACTIVATE   = 4'd2,
    CMD_READ       = 4'd3,
    CMD_WRITE      = 4'd4,
    CMD_PRECHARGE  = 4'd5,
    CMD_AUTO_REF   = 4'd6,
    CMD_MODE_SET   = 4'd7,
    CMD_BURST_STOP = 4'd8,
    CMD_SELF_REF   = 4'd9,
    CMD_POWER_DOWN = 4'd10,
    CMD_SUSPEND    = 4'd11,
    CMD_CKE_EXIT   = 4'd12,
    CMD_CKE_HOLD   = 4'd13
  } cmdCode_e;

  // Strobes handed from the decode path to the bank controller each cycle
  typedef struct packed {
    cmdCode_e cmd;
    logic     apFlag;
    logic     allFlag;
    logic     advance;  // clock enable high at this edge: counters may move
  } cmdStrobe_t;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              addr10,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              burstActive,
  output cmdStrobe_t        strobeNow,
  output cmdCode_e          cmdQ,
  output logic [BANK_W-1:0] bankQ,
  output logic              apQ,
  output logic              allQ
);

  logic ckePrev;

  always_comb begin
    strobeNow.cmd     = CMD_NOP;
    strobeNow.apFlag  = 1'b0;
    strobeNow.allFlag = 1'b0;
    strobeNow.advance = cke;
    if (!ckePrev) begin
      strobeNow.cmd = cke ? CMD_CKE_EXIT : CMD_CKE_HOLD;
    end else if (!cke) begin
      if (!csN && !rasN && !casN && weN) strobeNow.cmd = CMD_SELF_REF;
      else strobeNow.cmd = burstActive ? CMD_SUSPEND : CMD_POWER_DOWN;
    end else if (csN) begin
      strobeNow.cmd = CMD_DESELECT;
    end else begin
      case ({rasN, casN, weN})
        3'b011: strobeNow.cmd = CMD_ACTIVATE;
        3'b101: begin strobeNow.cmd = CMD_READ;      strobeNow.apFlag  = addr10; end
        3'b100: begin strobeNow.cmd = CMD_WRITE;     strobeNow.apFlag  = addr10; end
        3'b010: begin strobeNow.cmd = CMD_PRECHARGE; strobeNow.allFlag = addr10; end
        3'b001: strobeNow.cmd = CMD_AUTO_REF;
        3'b000: strobeNow.cmd = CMD_MODE_SET;
        3'b110: strobeNow.cmd = CMD_BURST_STOP;
        default: strobeNow.cmd = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev <= 1'b1;
      cmdQ    <= CMD_NOP;
      bankQ   <= '0;
      apQ     <= 1'b0;
      allQ    <= 1'b0;
    end else begin
      ckePrev <= cke;
      cmdQ    <= strobeNow.cmd;
      bankQ   <= bankSel;
      apQ     <= strobeNow.apFlag;
      allQ    <= strobeNow.allFlag;
    end
  end

  // R4
  deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cke && ckePrev && csN) |=> (cmdQ == CMD_DESELECT));

  // R7
  suspend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_SUSPEND) |-> $past(burstActive));

endmodule

// File: rtl/sdcmd_bank_ctrl.sv
module sdcmd_bank_ctrl
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 8,
  parameter int AP_DELAY  = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cmdStrobe_t                   strobeNow,
  input  logic [$clog2(NUM_BANKS)-1:0] bankNow,
  output logic                         burstActive,
  output logic                         illegalQ
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int BL_W   = $clog2(BURST_LEN + 1);
  localparam int AP_W   = $clog2(AP_DELAY + 1);

  logic [NUM_BANKS-1:0] bankOpen;
  logic [NUM_BANKS-1:0] apPending;
  logic [BL_W-1:0]      burstCnt;
  logic [BANK_W-1:0]    burstBank;
  logic                 violation;
  logic                 tgtOpen;

  assign tgtOpen = bankOpen[bankNow];

  always_comb begin
    case (strobeNow.cmd)
      CMD_ACTIVATE:                          violation = tgtOpen;
      CMD_READ, CMD_WRITE:                   violation = !tgtOpen;
      CMD_BURST_STOP:                        violation = (bankOpen == '0);
      CMD_AUTO_REF, CMD_MODE_SET, CMD_SELF_REF: violation = (bankOpen != '0);
      default:                               violation = 1'b0;
    endcase
  end

  logic okAct, okRw, okPre, okStop;
  assign okAct  = !violation && strobeNow.cmd == CMD_ACTIVATE;
  assign okRw   = !violation && (strobeNow.cmd == CMD_READ || strobeNow.cmd == CMD_WRITE);
  assign okPre  = strobeNow.cmd == CMD_PRECHARGE;
  assign okStop = !violation && strobeNow.cmd == CMD_BURST_STOP;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic            openQ;
    logic [AP_W-1:0] apCnt;
    logic            hit;
    assign hit          = (bankNow == BANK_W'(g));
    assign bankOpen[g]  = openQ;
    assign apPending[g] = (apCnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        apCnt <= '0;
      end else if (okAct && hit) begin
        openQ <= 1'b1;
      end else if (okPre && (strobeNow.allFlag || hit)) begin
        openQ <= 1'b0;
        apCnt <= '0;
      end else if (okRw && strobeNow.apFlag && hit) begin
        apCnt <= AP_W'(AP_DELAY);
      end else if (strobeNow.advance && apCnt != '0) begin
        apCnt <= apCnt - 1'b1;
        if (apCnt == AP_W'(1)) openQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstCnt  <= '0;
      burstBank <= '0;
      illegalQ  <= 1'b0;
    end else begin
      illegalQ <= violation;
      if (okRw) begin
        burstCnt  <= BL_W'(BURST_LEN);
        burstBank <= bankNow;
      end else if (okStop) begin
        burstCnt <= '0;
      end else if (okPre && (strobeNow.allFlag || bankNow == burstBank)) begin
        burstCnt <= '0;
      end else if (strobeNow.advance && burstCnt != '0) begin
        burstCnt <= burstCnt - 1'b1;
      end
    end
  end

  assign burstActive = (burstCnt != '0);

  // R11
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (violation && apPending == '0) |=> (bankOpen == $past(bankOpen)));

  // R9
  act_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeNow.cmd == CMD_ACTIVATE && !violation) |=> bankOpen[$past(bankNow)]);

  // R7
  burst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstCnt != '0 && $past(burstCnt) == '0) |->
      $past(strobeNow.cmd == CMD_READ || strobeNow.cmd == CMD_WRITE));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int BURST_LEN = 8,
  parameter  int AP_DELAY  = 6,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              addr10,
  input  logic [BANK_W-1:0] bankSel,
  output logic [3:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic              autoPre,
  output logic              allBanks,
  output logic              illegalCmd
);

  cmdStrobe_t strobeNow;
  cmdCode_e   cmdQ;
  logic       burstActive;

  sdcmd_decode #(.BANK_W(BANK_W)) decode_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addr10(addr10), .bankSel(bankSel), .burstActive(burstActive),
    .strobeNow(strobeNow), .cmdQ(cmdQ), .bankQ(cmdBank), .apQ(autoPre),
    .allQ(allBanks)
  );

  sdcmd_bank_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN), .AP_DELAY(AP_DELAY)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .strobeNow(strobeNow), .bankNow(bankSel),
    .burstActive(burstActive), .illegalQ(illegalCmd)
  );

  assign cmdCode = cmdQ;

  // R8
  illegal_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> (cmdQ inside {CMD_ACTIVATE, CMD_READ, CMD_WRITE, CMD_BURST_STOP,
                                 CMD_AUTO_REF, CMD_MODE_SET, CMD_SELF_REF}));

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb_top;
  import sdcmd_pkg::*;

  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100, P_PRE = 3'b010,
                         P_REF = 3'b001, P_MRS = 3'b000, P_BST = 3'b110, P_NOP = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, addr10 = 1'b0;
  logic [1:0] bankSel = 2'd0;
  logic [3:0] cmdCode;
  logic [1:0] cmdBank;
  logic autoPre, allBanks, illegalCmd;
  int tests = 0, fails = 0;
  logic [1:0] lastBa = 2'd0;

  always #2 clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(4), .BURST_LEN(4), .AP_DELAY(3)) dut_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addr10(addr10), .bankSel(bankSel), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .autoPre(autoPre), .allBanks(allBanks), .illegalCmd(illegalCmd)
  );

  task automatic chk(string tag, cmdCode_e eCmd, logic eAp, logic eAll, logic eIll);
    tests++;
    if (cmdCode !== eCmd || cmdBank !== lastBa || autoPre !== eAp ||
        allBanks !== eAll || illegalCmd !== eIll) begin
      fails++;
      $display("FAIL %s: got cmd=%0d bank=%0d ap=%b all=%b ill=%b, exp cmd=%0d bank=%0d ap=%b all=%b ill=%b",
               tag, cmdCode, cmdBank, autoPre, allBanks, illegalCmd,
               eCmd, lastBa, eAp, eAll, eIll);
    end
  endtask

  // Drive one edge worth of pins, then check the result after that edge
  task automatic op(string tag, logic c, logic s, logic [2:0] p, logic a10, logic [1:0] b,
                    cmdCode_e eCmd, logic eAp, logic eAll, logic eIll);
    @(negedge clk);
    cke = c; csN = s; {rasN, casN, weN} = p; addr10 = a10; bankSel = b;
    @(posedge clk); #1;
    lastBa = b;
    chk(tag, eCmd, eAp, eAll, eIll);
  endtask

  task automatic nop(string tag);
    op(tag, 1, 0, P_NOP, 0, 0, CMD_NOP, 0, 0, 0);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1; lastBa = 2'd0;
    chk("R1 reset outputs", CMD_NOP, 0, 0, 0);
    @(negedge clk); rstN = 1'b1;
    op("R1 read after reset is illegal (banks closed)", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 1);
  endtask

  task automatic testDecode();
    nop("R3 nop");
    op("R3 R9 activate b1", 1, 0, P_ACT, 0, 1, CMD_ACTIVATE, 0, 0, 0);
    op("R3 R2 read b1", 1, 0, P_RD, 0, 1, CMD_READ, 0, 0, 0);
    op("R3 write b1", 1, 0, P_WR, 0, 1, CMD_WRITE, 0, 0, 0);
    op("R3 R8 burst stop with open bank", 1, 0, P_BST, 0, 1, CMD_BURST_STOP, 0, 0, 0);
    op("R8 mode set with open bank", 1, 0, P_MRS, 0, 1, CMD_MODE_SET, 0, 0, 1);
    op("R8 auto refresh with open bank", 1, 0, P_REF, 0, 1, CMD_AUTO_REF, 0, 0, 1);
    op("R5 R9 precharge b1", 1, 0, P_PRE, 0, 1, CMD_PRECHARGE, 0, 0, 0);
    op("R3 R8 auto refresh all idle", 1, 0, P_REF, 0, 0, CMD_AUTO_REF, 0, 0, 0);
    op("R3 R8 mode set all idle", 1, 0, P_MRS, 0, 0, CMD_MODE_SET, 0, 0, 0);
    op("R8 R9 read to closed b1", 1, 0, P_RD, 0, 1, CMD_READ, 0, 0, 1);
    op("R8 burst stop with no open bank", 1, 0, P_BST, 0, 0, CMD_BURST_STOP, 0, 0, 1);
  endtask

  task automatic testAllBanks();
    op("R9 activate b0", 1, 0, P_ACT, 0, 0, CMD_ACTIVATE, 0, 0, 0);
    op("R9 activate b2", 1, 0, P_ACT, 0, 2, CMD_ACTIVATE, 0, 0, 0);
    op("R5 precharge all", 1, 0, P_PRE, 1, 3, CMD_PRECHARGE, 0, 1, 0);
    op("R5 read b0 after all", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 1);
    op("R5 write b2 after all", 1, 0, P_WR, 0, 2, CMD_WRITE, 0, 0, 1);
    op("R5 activate b0 again", 1, 0, P_ACT, 0, 0, CMD_ACTIVATE, 0, 0, 0);
    op("R5 write b0 autoPre flag", 1, 0, P_WR, 1, 0, CMD_WRITE, 1, 0, 0);
    op("R9 precharge b0", 1, 0, P_PRE, 0, 0, CMD_PRECHARGE, 0, 0, 0);
  endtask

  task automatic testIllegal();
    op("R11 activate b3", 1, 0, P_ACT, 0, 3, CMD_ACTIVATE, 0, 0, 0);
    op("R11 R8 activate open b3", 1, 0, P_ACT, 0, 3, CMD_ACTIVATE, 0, 0, 1);
    nop("R11 flag lasts one cycle");
    op("R11 b3 still open", 1, 0, P_RD, 0, 3, CMD_READ, 0, 0, 0);
    op("R11 precharge b3", 1, 0, P_PRE, 0, 3, CMD_PRECHARGE, 0, 0, 0);
    op("R11 illegal read b3", 1, 0, P_RD, 0, 3, CMD_READ, 0, 0, 1);
    op("R11 b3 stayed closed", 1, 0, P_ACT, 0, 3, CMD_ACTIVATE, 0, 0, 0);
    op("R11 close b3", 1, 0, P_PRE, 0, 3, CMD_PRECHARGE, 0, 0, 0);
  endtask

  task automatic testDeselectAp();
    op("R10 activate b2", 1, 0, P_ACT, 0, 2, CMD_ACTIVATE, 0, 0, 0);
    op("R10 read b2 auto-precharge", 1, 0, P_RD, 1, 2, CMD_READ, 1, 0, 0);
    op("R4 deselect 1", 1, 1, P_ACT, 0, 2, CMD_DESELECT, 0, 0, 0);
    op("R4 deselect 2", 1, 1, P_RD, 1, 2, CMD_DESELECT, 0, 0, 0);
    op("R10 activate at AP_DELAY edge", 1, 0, P_ACT, 0, 2, CMD_ACTIVATE, 0, 0, 1);
    op("R10 R4 activate one edge later", 1, 0, P_ACT, 0, 2, CMD_ACTIVATE, 0, 0, 0);
    op("R10 close b2", 1, 0, P_PRE, 0, 2, CMD_PRECHARGE, 0, 0, 0);
  endtask

  task automatic testCke();
    op("R7 power down no burst", 0, 1, P_NOP, 0, 0, CMD_POWER_DOWN, 0, 0, 0);
    op("R6 hold ignores activate", 0, 0, P_ACT, 0, 0, CMD_CKE_HOLD, 0, 0, 0);
    op("R6 exit", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    op("R6 activate was ignored", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 1);
    op("R6 self refresh entry", 0, 0, P_REF, 0, 0, CMD_SELF_REF, 0, 0, 0);
    op("R6 self refresh hold", 0, 0, P_REF, 0, 0, CMD_CKE_HOLD, 0, 0, 0);
    op("R6 refresh pattern at exit edge", 1, 0, P_REF, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    op("R6 auto refresh after exit", 1, 0, P_REF, 0, 0, CMD_AUTO_REF, 0, 0, 0);
    op("R6 activate b1", 1, 0, P_ACT, 0, 1, CMD_ACTIVATE, 0, 0, 0);
    op("R8 self refresh with open bank", 0, 0, P_REF, 0, 1, CMD_SELF_REF, 0, 0, 1);
    op("R6 exit after bad self refresh", 1, 1, P_NOP, 0, 1, CMD_CKE_EXIT, 0, 0, 0);
    op("R11 b1 still open", 1, 0, P_PRE, 0, 1, CMD_PRECHARGE, 0, 0, 0);
  endtask

  task automatic testSuspend();
    op("R7 activate b0", 1, 0, P_ACT, 0, 0, CMD_ACTIVATE, 0, 0, 0);
    op("R7 read b0", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 0);
    repeat (3) nop("R7 nop in burst");
    op("R7 cke low at BURST_LEN edge", 0, 1, P_NOP, 0, 0, CMD_SUSPEND, 0, 0, 0);
    op("R7 exit", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    op("R7 cke low after burst", 0, 1, P_NOP, 0, 0, CMD_POWER_DOWN, 0, 0, 0);
    op("R7 exit 2", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    op("R7 read b0 again", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 0);
    repeat (4) nop("R7 nop to burst end");
    op("R7 cke low at BURST_LEN+1 edge", 0, 1, P_NOP, 0, 0, CMD_POWER_DOWN, 0, 0, 0);
    op("R7 exit 3", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    op("R13 read b0", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 0);
    op("R13 suspend at once", 0, 1, P_NOP, 0, 0, CMD_SUSPEND, 0, 0, 0);
    op("R13 hold 1", 0, 1, P_NOP, 0, 0, CMD_CKE_HOLD, 0, 0, 0);
    op("R13 hold 2", 0, 1, P_NOP, 0, 0, CMD_CKE_HOLD, 0, 0, 0);
    op("R13 exit", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    repeat (2) nop("R13 nop");
    op("R13 burst frozen while low", 0, 1, P_NOP, 0, 0, CMD_SUSPEND, 0, 0, 0);
    op("R13 exit 2", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    op("R12 read b0", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 0);
    op("R12 burst stop", 1, 0, P_BST, 0, 0, CMD_BURST_STOP, 0, 0, 0);
    op("R12 cke low after stop", 0, 1, P_NOP, 0, 0, CMD_POWER_DOWN, 0, 0, 0);
    op("R12 exit", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
    op("R12 read b0 before precharge", 1, 0, P_RD, 0, 0, CMD_READ, 0, 0, 0);
    op("R12 precharge b0 ends burst", 1, 0, P_PRE, 0, 0, CMD_PRECHARGE, 0, 0, 0);
    op("R12 cke low after precharge", 0, 1, P_NOP, 0, 0, CMD_POWER_DOWN, 0, 0, 0);
    op("R12 exit 2", 1, 1, P_NOP, 0, 0, CMD_CKE_EXIT, 0, 0, 0);
  endtask

  initial begin
    testReset();
    testDecode();
    testAllBanks();
    testIllegal();
    testDeselectAp();
    testCke();
    testSuspend();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++;
    fails++;
    $display("FAIL watchdog: got running, exp finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule